// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a processor core and decides which event the core should service next. It takes a non-maskable reset request and a set of interrupt request lines. It then hands the core the program-memory address of the vector that has the highest priority. Vectors sit at the bottom of program memory, with reset at address zero. Each interrupt source owns the vector slot after the one before it, so a lower address always means higher priority.

Each request line is latched into a pending flag. An interrupt is accepted only when all of the following hold:
- its own enable bit is one;
- the global enable flag is one;
- no boot-protection lock is in force for the current program-counter region;
- no earlier vector is still waiting for the core.

On acceptance, the block does three things in the same cycle: it pulses a one-hot acknowledge to the winning source, pulses a global-enable clear, and drops the global enable flag. The vector address is registered so the core can fetch from it in the next cycle. The vector is held until the core signals that it has taken it. The global enable flag is written and read through a small status-register port.

Top module: `vec_intc`

## Requirements
- R1: After the asynchronous chip reset (rstN low), gieOut, vecValid, gieClr and every irqAck bit are 0, and no request is pending.
- R2: A one-cycle pulse on irqIn[k] sets a pending flag that stays set until that source is acknowledged, even while the global enable is 0.
- R3: A pending source is accepted only when its enable bit (written through enWrEn/enWrData, bit k for source k) is 1 and gieOut is 1.
- R4: When several enabled sources are pending, the lowest index k wins. Source k has vector address 2*(k+1); reset has address 0.
- R5: In the acceptance cycle, irqAck is one-hot on the winner and gieClr is 1, both combinationally. gieOut reads 0 from the next cycle on, and the acknowledged source's pending flag is cleared.
- R6: vecValid rises and vecAddr shows the winner's address in the cycle after acceptance. Both hold unchanged until takeReady is sampled high, and vecValid is 0 in the cycle after that.
- R7: While lockProg and pcInProt are both 1, no interrupt is accepted, but pending flags are kept. Once either input falls, the held request is accepted.
- R8: resetReq is non-maskable and beats any interrupt and any lock. In the same cycle it pulses gieClr with no irqAck. In the next cycle vecValid is 1 and vecAddr is 0, and gieOut, all enable bits and all pending flags are 0.
- R9: sregWrEn loads sregWrGie into the global enable, visible on gieOut the next cycle. An acceptance in the same cycle overrides the write and leaves the flag at 0.
- R10: While vecValid is 1, no further interrupt is accepted, even if the global enable has been set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low chip reset |
| resetReq | input | 1 | Non-maskable reset vector request |
| irqIn | input | NUM_SRC | Interrupt request lines, bit k is source k |
| enWrEn | input | 1 | Write strobe for the individual enables |
| enWrData | input | NUM_SRC | New individual enable bits |
| sregWrEn | input | 1 | Write strobe for the global enable flag |
| sregWrGie | input | 1 | Value written to the global enable flag |
| gieOut | output | 1 | Current global enable flag |
| lockProg | input | 1 | Boot-protection lock is programmed |
| pcInProt | input | 1 | Program counter lies in the protected section |
| takeReady | input | 1 | Core has taken the presented vector |
| vecValid | output | 1 | A vector is waiting for the core |
| vecAddr | output | ADDR_W | Vector address in program words |
| irqAck | output | NUM_SRC | One-cycle acknowledge to the winning source |
| gieClr | output | 1 | One-cycle pulse: global enable is being cleared |

## Verification
Acknowledge and gieClr are combinational. They are due in the same cycle that a latched, enabled request meets a set global enable. vecValid, vecAddr and gieOut come from one register stage, so they are due one edge after the acceptance, write or reset request that changes them. A raw request pulse needs one edge to reach its pending flag before it can be acknowledged. The bench drives every input on the falling edge. It reads the combinational results shortly after that edge and before the next rising edge, and it reads the registered results on the falling edge after the rising edge that loads them.

// File: rtl/vi_pkg.sv
package vi_pkg;
  // Strobes from control to datapath, one cycle wide.
  typedef struct packed {
    logic accept;    // an interrupt wins this cycle
    logic rstTake;   // reset request is being taken
    logic vecTaken;  // core consumed the held vector
  } viStrobe_t;
endpackage

// File: rtl/vi_ctrl.sv
module vi_ctrl
  import vi_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               resetReq,
  input  logic               takeReady,
  input  logic               lockProg,
  input  logic               pcInProt,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en,
  input  logic               gie,
  input  logic               vecValid,
  output viStrobe_t          strb,
  output logic [NUM_SRC-1:0] ackHot,
  output logic [IDX_W-1:0]   winIdx
);
  logic blocked;
  logic [NUM_SRC-1:0] req;
  logic anyReq;

  assign blocked = lockProg & pcInProt;
  assign req = pend & en & {NUM_SRC{gie & ~blocked}};
  assign anyReq = |req;

  // Lowest index wins: scan downward so the last hit is the smallest.
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) winIdx = IDX_W'(i);
    end
  end

  always_comb begin
    strb.rstTake  = resetReq;
    strb.accept   = anyReq & ~vecValid & ~resetReq;
    strb.vecTaken = vecValid & takeReady;
    ackHot = strb.accept ? (req & (~req + NUM_SRC'(1))) : '0;
  end
endmodule

// File: rtl/vi_dpath.sv
module vi_dpath
  import vi_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int ADDR_W   = 16,
  parameter int VEC_STEP = 2,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  viStrobe_t          strb,
  input  logic [NUM_SRC-1:0] ackHot,
  input  logic [IDX_W-1:0]   winIdx,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               enWrEn,
  input  logic [NUM_SRC-1:0] enWrData,
  input  logic               sregWrEn,
  input  logic               sregWrGie,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] en,
  output logic               gie,
  output logic               vecValid,
  output logic [ADDR_W-1:0]  vecAddr
);
  logic [ADDR_W-1:0] winAddr;
  assign winAddr = (ADDR_W'(winIdx) + ADDR_W'(1)) * ADDR_W'(VEC_STEP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= '0;
      en       <= '0;
      gie      <= 1'b0;
      vecValid <= 1'b0;
      vecAddr  <= '0;
    end else if (strb.rstTake) begin
      pend     <= '0;
      en       <= '0;
      gie      <= 1'b0;
      vecValid <= 1'b1;
      vecAddr  <= '0;
    end else begin
      pend <= (pend & ~ackHot) | irqIn;
      if (enWrEn) en <= enWrData;
      if (strb.accept) gie <= 1'b0;
      else if (sregWrEn) gie <= sregWrGie;
      if (strb.accept) begin
        vecValid <= 1'b1;
        vecAddr  <= winAddr;
      end else if (strb.vecTaken) begin
        vecValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vi_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int ADDR_W   = 16,
  parameter int VEC_STEP = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               resetReq,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               enWrEn,
  input  logic [NUM_SRC-1:0] enWrData,
  input  logic               sregWrEn,
  input  logic               sregWrGie,
  output logic               gieOut,
  input  logic               lockProg,
  input  logic               pcInProt,
  input  logic               takeReady,
  output logic               vecValid,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [NUM_SRC-1:0] irqAck,
  output logic               gieClr
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  viStrobe_t strb;
  logic [NUM_SRC-1:0] pend, en, ackHot;
  logic [IDX_W-1:0] winIdx;
  logic gie;

  vi_ctrl #(.NUM_SRC(NUM_SRC)) uCtrl (
    .resetReq(resetReq), .takeReady(takeReady), .lockProg(lockProg),
    .pcInProt(pcInProt), .pend(pend), .en(en), .gie(gie),
    .vecValid(vecValid), .strb(strb), .ackHot(ackHot), .winIdx(winIdx)
  );

  vi_dpath #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_STEP(VEC_STEP)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .ackHot(ackHot), .winIdx(winIdx),
    .irqIn(irqIn), .enWrEn(enWrEn), .enWrData(enWrData),
    .sregWrEn(sregWrEn), .sregWrGie(sregWrGie), .pend(pend), .en(en),
    .gie(gie), .vecValid(vecValid), .vecAddr(vecAddr)
  );

  assign gieOut = gie;
  assign irqAck = ackHot;
  assign gieClr = strb.accept | strb.rstTake;
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               resetReq,
  input logic               lockProg,
  input logic               pcInProt,
  input logic               takeReady,
  input logic               gieOut,
  input logic               vecValid,
  input logic [ADDR_W-1:0]  vecAddr,
  input logic [NUM_SRC-1:0] irqAck,
  input logic               gieClr
);
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqAck)); // R5
  AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    (|irqAck) |=> !gieOut && vecValid); // R5
  AST_ACK_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    !gieOut |-> irqAck == '0); // R3
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (lockProg && pcInProt) |-> irqAck == '0); // R7
  AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> vecValid && vecAddr == '0 && !gieOut); // R8
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && !takeReady && !resetReq) |=> vecValid && $stable(vecAddr)); // R6
  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> irqAck == '0); // R10
  AST_CLR_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (|irqAck) |-> gieClr); // R5
endmodule

bind vec_intc vec_intc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .resetReq(resetReq), .lockProg(lockProg),
  .pcInProt(pcInProt), .takeReady(takeReady), .gieOut(gieOut),
  .vecValid(vecValid), .vecAddr(vecAddr), .irqAck(irqAck), .gieClr(gieClr)
);

// File: tb/tb_vec_intc.sv
`timescale 1ns/1ps
module tb_vec_intc;
  localparam int N = 8;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resetReq = 1'b0;
  logic [N-1:0] irqIn = '0;
  logic enWrEn = 1'b0;
  logic [N-1:0] enWrData = '0;
  logic sregWrEn = 1'b0;
  logic sregWrGie = 1'b0;
  logic gieOut;
  logic lockProg = 1'b0;
  logic pcInProt = 1'b0;
  logic takeReady = 1'b0;
  logic vecValid;
  logic [AW-1:0] vecAddr;
  logic [N-1:0] irqAck;
  logic gieClr;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vec_intc #(.NUM_SRC(N), .ADDR_W(AW)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench expectation for source k's vector address.
  function automatic logic [31:0] addrOf(input int k);
    return 32'(2 * (k + 1));
  endfunction

  task automatic setEn(input logic [N-1:0] v);
    @(negedge clk); enWrEn = 1'b1; enWrData = v;
    @(negedge clk); enWrEn = 1'b0;
  endtask

  task automatic setGie(input logic b);
    @(negedge clk); sregWrEn = 1'b1; sregWrGie = b;
    @(negedge clk); sregWrEn = 1'b0;
  endtask

  task automatic pulseIrq(input logic [N-1:0] v);
    @(negedge clk); irqIn = v;
    @(negedge clk); irqIn = '0;
  endtask

  task automatic takeVec();
    takeReady = 1'b1;
    @(negedge clk); takeReady = 1'b0;
    chk("R6 vecValid after take", 32'(vecValid), 0);
  endtask

  task automatic tReset();
    chk("R1 gieOut", 32'(gieOut), 0);
    chk("R1 vecValid", 32'(vecValid), 0);
    chk("R1 irqAck", 32'(irqAck), 0);
    chk("R1 gieClr", 32'(gieClr), 0);
  endtask

  task automatic tPriority();
    setEn('1);
    pulseIrq(8'b0010_0100);
    #1 chk("R2 held while gie off", 32'(irqAck), 0);
    setGie(1'b1);
    #1;
    chk("R4 lowest wins", 32'(irqAck), 32'h04);
    chk("R5 gieClr pulse", 32'(gieClr), 1);
    @(negedge clk);
    chk("R6 vecValid", 32'(vecValid), 1);
    chk("R4 vecAddr src2", 32'(vecAddr), addrOf(2));
    chk("R5 gie cleared", 32'(gieOut), 0);
    chk("R5 ack one cycle", 32'(irqAck), 0);
    @(negedge clk);
    chk("R6 held", 32'(vecValid), 1);
    chk("R6 addr held", 32'(vecAddr), addrOf(2));
    takeVec();
    setGie(1'b1);
    #1 chk("R2 second source kept", 32'(irqAck), 32'h20);
    @(negedge clk);
    chk("R4 vecAddr src5", 32'(vecAddr), addrOf(5));
    takeVec();
  endtask

  task automatic tEnable();
    setEn(8'b1111_1101);
    pulseIrq(8'b0000_0010);
    setGie(1'b1);
    #1 chk("R3 disabled source ignored", 32'(irqAck), 0);
    @(negedge clk);
    chk("R3 no vector", 32'(vecValid), 0);
    chk("R3 gie stays", 32'(gieOut), 1);
    setEn('1);
    #1 chk("R3 enabled later", 32'(irqAck), 32'h02);
    @(negedge clk);
    chk("R4 vecAddr src1", 32'(vecAddr), addrOf(1));
    takeVec();
  endtask

  task automatic tLock();
    lockProg = 1'b1; pcInProt = 1'b1;
    pulseIrq(8'b1000_0000);
    setGie(1'b1);
    #1 chk("R7 blocked", 32'(irqAck), 0);
    @(negedge clk);
    chk("R7 no vector", 32'(vecValid), 0);
    pcInProt = 1'b0;
    #1 chk("R7 released", 32'(irqAck), 32'h80);
    @(negedge clk);
    chk("R4 vecAddr src7", 32'(vecAddr), addrOf(7));
    lockProg = 1'b0;
    // R10: gie set again while vector still waits
    setGie(1'b1);
    pulseIrq(8'b0000_0001);
    #1 chk("R10 no accept while busy", 32'(irqAck), 0);
    chk("R10 addr unchanged", 32'(vecAddr), addrOf(7));
    takeVec();
    #1 chk("R10 accept after take", 32'(irqAck), 32'h01);
    @(negedge clk);
    chk("R4 vecAddr src0", 32'(vecAddr), addrOf(0));
    takeVec();
  endtask

  task automatic tSregOverride();
    setGie(1'b1);
    chk("R9 gie write", 32'(gieOut), 1);
    setGie(1'b0);
    chk("R9 gie clear write", 32'(gieOut), 0);
    setGie(1'b1);
    @(negedge clk); irqIn = 8'b0000_1000; sregWrEn = 1'b1; sregWrGie = 1'b1;
    @(negedge clk); irqIn = '0;
    #1 chk("R9 accept with write", 32'(irqAck), 32'h08);
    @(negedge clk); sregWrEn = 1'b0;
    chk("R9 accept beats write", 32'(gieOut), 0);
    takeVec();
  endtask

  task automatic tResetReq();
    setGie(1'b1);
    lockProg = 1'b1; pcInProt = 1'b1;
    @(negedge clk); irqIn = 8'b0001_0000; resetReq = 1'b1;
    #1;
    chk("R8 gieClr", 32'(gieClr), 1);
    chk("R8 no irqAck", 32'(irqAck), 0);
    @(negedge clk); resetReq = 1'b0; irqIn = '0;
    chk("R8 vecValid", 32'(vecValid), 1);
    chk("R8 vecAddr zero", 32'(vecAddr), 0);
    chk("R8 gie zero", 32'(gieOut), 0);
    lockProg = 1'b0; pcInProt = 1'b0;
    takeVec();
    setGie(1'b1);
    pulseIrq(8'b0100_0000);
    #1 chk("R8 enables cleared", 32'(irqAck), 0);
    @(negedge clk);
    chk("R8 no vector", 32'(vecValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPriority();
    tEnable();
    tLock();
    tSregOverride();
    tResetReq();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule